// File: doc/BRIEF.md
# Parallel Flash Programming Mode Controller

This block models the parallel programming port of a small on-chip program memory that carries a security register. An external programmer drives several inputs: an active-low chip enable, an active-low output enable, a 2-bit code for the programming-voltage level, a security-select line, a 16-bit address and a data byte. From these the block chooses one operation. The operations are read, output disable, standby, byte program, program verify, whole-array erase, erase verify and inhibit. The data bus is bidirectional in hardware; here it appears as a separate input byte, output byte and output enable.

Stored bits behave like flash cells. A byte program can only move bits from 1 to 0. Only a whole-array erase moves them back to 1, and the same erase also restores the security register. When the lock bit in the security register is programmed to 0, array read data is masked. Several devices can share every line except their two enables, so a programmer can write different data into each one in turn while the others stay inhibited.

Voltage-level code: 2'b00 is normal, 2'b01 is the program level, 2'b10 is the erase level, and 2'b11 behaves like normal.

Top module: `pflash_prog_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `dout_en` is 0 and `dout` is 8'h00. Reset brings every array byte and the security register to 8'hFF.
- R2: Outputs are registered, so a value appears one clock after its inputs. `dout_en` is 1 only for three input combinations: read (`ce_n`=0, `oe_n`=0, any level), program verify and erase verify. With `oe_n`=1, or with `ce_n`=1, `oe_n`=0 at normal level, `dout_en` is 0 and `dout` is 8'h00.
- R3: Byte program requires level 2'b01, `ce_n`=0 and `oe_n`=1. It stores old AND `din` at the addressed byte, so a bit that is already 0 stays 0.
- R4: A program or erase takes effect only once on entry into its mode. Holding the mode, changing the address or data while held, or switching directly between program and erase, writes nothing more until a cycle in any other mode.
- R5: Erase requires level 2'b10, `ce_n`=0 and `oe_n`=1. It sets every array byte and the security register to 8'hFF in one cycle.
- R6: Program verify (level 2'b01, `ce_n`=1, `oe_n`=0) drives the stored byte at the address.
- R7: Erase verify (level 2'b10, `ce_n`=1, `oe_n`=0) drives the stored byte at the address.
- R8: With `ce_n`=1 and `oe_n`=1, nothing is written, whatever the level, address and data.
- R9: When security bit 0 (the lock bit) is 0, every array read, including both verify modes, returns 8'hFF. Reads of the security register are never masked.
- R10: With `sec_sel`=1, the security register sits at address index 0. Other addresses read 8'hFF, and programs to them are ignored.
- R11: Address bits at or above log2(DEPTH) are ignored, so addresses 0x0110 and 0x0010 name the same byte (DEPTH=256).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| vlevel | input | 2 | Programming-voltage level code |
| sec_sel | input | 1 | Selects the security register space |
| addr | input | 16 | Byte address |
| din | input | 8 | Program data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Output drive enable for the data bus |

## Verification
The hardest state to reach from the ports is a program or erase condition that stays asserted while the address or the mode changes underneath it. The stimulus holds the program condition across two cycles with a new address and data on the second. It also switches straight from program to erase without an intervening mode. Reads afterwards show that neither the second write nor the erase took place. The locked state is entered by programming the lock bit through the security space. After that, normal reads and erase-verify reads both come back masked, while the security register itself still reads its true value.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

    typedef enum logic [1:0] {
        VL_NORM  = 2'b00,
        VL_PROG  = 2'b01,
        VL_ERASE = 2'b10,
        VL_RSVD  = 2'b11
    } vlevel_e;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_READ,
        M_OUTDIS,
        M_PROG,
        M_PVER,
        M_ERASE,
        M_EVER,
        M_INHIBIT
    } mode_e;

endpackage

// File: rtl/pflash_mode_decode.sv
module pflash_mode_decode
    import pflash_pkg::*;
(
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic [1:0] vlevel,
    output mode_e      mode,
    output logic       prog_req,
    output logic       erase_req
);

    vlevel_e lvl;

    always_comb begin
        lvl = vlevel_e'(vlevel);
        mode = M_STANDBY;
        unique case ({ce_n, oe_n})
            2'b11: mode = M_INHIBIT;
            2'b00: mode = M_READ;
            2'b01: begin
                if (lvl == VL_PROG)       mode = M_PROG;
                else if (lvl == VL_ERASE) mode = M_ERASE;
                else                      mode = M_OUTDIS;
            end
            default: begin
                if (lvl == VL_PROG)       mode = M_PVER;
                else if (lvl == VL_ERASE) mode = M_EVER;
                else                      mode = M_STANDBY;
            end
        endcase
        prog_req  = (mode == M_PROG);
        erase_req = (mode == M_ERASE);
    end

endmodule

// File: rtl/pflash_store.sv
module pflash_store #(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 256,
    parameter int SEC_ADDR = 0,
    parameter int LOCK_BIT = 0,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_req,
    input  logic              erase_req,
    input  logic              sec_sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] arr_byte,
    output logic [DATA_W-1:0] sec_byte,
    output logic              sec_hit,
    output logic              lock_n
);

    localparam logic [IDX_W-1:0] SEC_IDX = IDX_W'(SEC_ADDR);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]            sec;
        logic                         busy;
    } store_t;

    store_t s_d, s_q;
    logic   wr_fire;

    always_comb begin
        s_d     = s_q;
        sec_hit = (idx == SEC_IDX);
        wr_fire = (prog_req || erase_req) && !s_q.busy;
        if (!(prog_req || erase_req)) begin
            s_d.busy = 1'b0;
        end else if (wr_fire) begin
            s_d.busy = 1'b1;
            if (erase_req) begin
                s_d.mem = '1;
                s_d.sec = '1;
            end else if (sec_sel) begin
                if (sec_hit) s_d.sec = s_q.sec & din;
            end else begin
                s_d.mem[idx] = s_q.mem[idx] & din;
            end
        end
        arr_byte = s_q.mem[idx];
        sec_byte = s_q.sec;
        lock_n   = s_q.sec[LOCK_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mem  <= '1;
            s_q.sec  <= '1;
            s_q.busy <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R8
    hold_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_req || erase_req) |=> $stable(s_q.sec));

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && (prog_req || erase_req)) |=> $stable(s_q.mem));

    // R5
    erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !s_q.busy) |=> (s_q.sec == '1 && s_q.mem == '1));

    // R9
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.sec[LOCK_BIT]) |-> $past(prog_req));

endmodule

// File: rtl/pflash_out_stage.sv
module pflash_out_stage
    import pflash_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic              sec_sel,
    input  logic              sec_hit,
    input  logic              lock_n,
    input  logic [DATA_W-1:0] arr_byte,
    input  logic [DATA_W-1:0] sec_byte,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d.en   = (mode == M_READ) || (mode == M_PVER) || (mode == M_EVER);
        o_d.data = '0;
        if (o_d.en) begin
            if (sec_sel)     o_d.data = sec_hit ? sec_byte : '1;
            else if (lock_n) o_d.data = arr_byte;
            else             o_d.data = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign dout    = o_q.data;
    assign dout_en = o_q.en;

    // R9
    mask_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_d.en && !sec_sel && !lock_n) |=> (dout == '1));

endmodule

// File: rtl/pflash_prog_ctrl.sv
module pflash_prog_ctrl
    import pflash_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 256,
    parameter int SEC_ADDR = 0,
    parameter int LOCK_BIT = 0,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [1:0]        vlevel,
    input  logic              sec_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    mode_e             mode;
    logic              prog_req, erase_req;
    logic [DATA_W-1:0] arr_byte, sec_byte;
    logic              sec_hit, lock_n;
    logic [IDX_W-1:0]  idx;
    logic              unused_hi;

    // R11: high address bits do not reach the store
    assign idx       = addr[IDX_W-1:0];
    assign unused_hi = ^addr[ADDR_W-1:IDX_W];

    pflash_mode_decode u_dec (
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .vlevel    (vlevel),
        .mode      (mode),
        .prog_req  (prog_req),
        .erase_req (erase_req)
    );

    pflash_store #(
        .DATA_W   (DATA_W),
        .DEPTH    (DEPTH),
        .SEC_ADDR (SEC_ADDR),
        .LOCK_BIT (LOCK_BIT)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_req  (prog_req),
        .erase_req (erase_req),
        .sec_sel   (sec_sel),
        .idx       (idx),
        .din       (din),
        .arr_byte  (arr_byte),
        .sec_byte  (sec_byte),
        .sec_hit   (sec_hit),
        .lock_n    (lock_n)
    );

    pflash_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .sec_sel  (sec_sel),
        .sec_hit  (sec_hit),
        .lock_n   (lock_n),
        .arr_byte (arr_byte),
        .sec_byte (sec_byte),
        .dout     (dout),
        .dout_en  (dout_en)
    );

    // R2
    oe_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (!dout_en && dout == '0));

    // R8
    inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && oe_n) |-> (!prog_req && !erase_req));

endmodule

// File: tb/pflash_prog_ctrl_bench.sv
module pflash_prog_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [1:0]  vlevel = 2'b00;
    logic        sec_sel = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pflash_prog_ctrl u_pflash_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vlevel(vlevel),
        .sec_sel(sec_sel), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    typedef struct packed {
        logic        ce_n;
        logic        oe_n;
        logic [1:0]  vl;
        logic        sec;
        logic [15:0] addr;
        logic [7:0]  din;
        logic        en;
        logic [7:0]  dout;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,2'b00,1'b0,16'h0010,8'h00,1'b1,8'hFF,4'd1},  // R1 erased after reset
        '{1'b0,1'b1,2'b01,1'b0,16'h0010,8'hA5,1'b0,8'h00,4'd3},  // R3 program
        '{1'b1,1'b0,2'b01,1'b0,16'h0010,8'h00,1'b1,8'hA5,4'd6},  // R6 verify
        '{1'b0,1'b1,2'b01,1'b0,16'h0010,8'h0F,1'b0,8'h00,4'd3},  // R3 AND
        '{1'b0,1'b0,2'b00,1'b0,16'h0010,8'h00,1'b1,8'h05,4'd3},
        '{1'b0,1'b1,2'b01,1'b0,16'h0010,8'hFF,1'b0,8'h00,4'd3},  // R3 no 0->1
        '{1'b0,1'b0,2'b00,1'b0,16'h0010,8'h00,1'b1,8'h05,4'd3},
        '{1'b0,1'b0,2'b00,1'b0,16'h0110,8'h00,1'b1,8'h05,4'd11}, // R11 alias
        '{1'b0,1'b1,2'b00,1'b0,16'h0010,8'h00,1'b0,8'h00,4'd2},  // R2 out disable
        '{1'b1,1'b0,2'b00,1'b0,16'h0010,8'h00,1'b0,8'h00,4'd2},  // R2 standby
        '{1'b1,1'b1,2'b01,1'b0,16'h0020,8'h00,1'b0,8'h00,4'd8},  // R8 inhibit prog
        '{1'b0,1'b0,2'b00,1'b0,16'h0020,8'h00,1'b1,8'hFF,4'd8},
        '{1'b1,1'b1,2'b10,1'b0,16'h0020,8'h00,1'b0,8'h00,4'd8},  // R8 inhibit erase
        '{1'b0,1'b0,2'b00,1'b0,16'h0010,8'h00,1'b1,8'h05,4'd8},
        '{1'b0,1'b1,2'b01,1'b0,16'h0030,8'h3C,1'b0,8'h00,4'd3},
        '{1'b0,1'b1,2'b01,1'b0,16'h0031,8'h00,1'b0,8'h00,4'd4},  // R4 held
        '{1'b0,1'b0,2'b00,1'b0,16'h0031,8'h00,1'b1,8'hFF,4'd4},
        '{1'b0,1'b0,2'b00,1'b0,16'h0030,8'h00,1'b1,8'h3C,4'd4},
        '{1'b0,1'b0,2'b11,1'b0,16'h0030,8'h00,1'b1,8'h3C,4'd2},  // R2 read any level
        '{1'b0,1'b1,2'b01,1'b1,16'h0005,8'h00,1'b0,8'h00,4'd10}, // R10 other sec addr
        '{1'b0,1'b0,2'b00,1'b1,16'h0000,8'h00,1'b1,8'hFF,4'd10},
        '{1'b0,1'b0,2'b00,1'b1,16'h0005,8'h00,1'b1,8'hFF,4'd10},
        '{1'b0,1'b1,2'b01,1'b1,16'h0000,8'hFE,1'b0,8'h00,4'd9},  // R9 set lock
        '{1'b0,1'b0,2'b00,1'b0,16'h0030,8'h00,1'b1,8'hFF,4'd9},  // R9 masked
        '{1'b0,1'b0,2'b00,1'b1,16'h0000,8'h00,1'b1,8'hFE,4'd9},  // R9 sec unmasked
        '{1'b1,1'b0,2'b10,1'b0,16'h0030,8'h00,1'b1,8'hFF,4'd9},  // R9 everify masked
        '{1'b0,1'b1,2'b10,1'b0,16'h0000,8'h00,1'b0,8'h00,4'd5},  // R5 erase
        '{1'b1,1'b0,2'b10,1'b0,16'h0010,8'h00,1'b1,8'hFF,4'd7},  // R7 erase verify
        '{1'b0,1'b0,2'b00,1'b1,16'h0000,8'h00,1'b1,8'hFF,4'd5},
        '{1'b0,1'b1,2'b01,1'b0,16'h0040,8'h12,1'b0,8'h00,4'd3},
        '{1'b0,1'b1,2'b10,1'b0,16'h0040,8'h00,1'b0,8'h00,4'd4},  // R4 direct switch
        '{1'b0,1'b0,2'b00,1'b0,16'h0040,8'h00,1'b1,8'h12,4'd4},
        '{1'b1,1'b0,2'b01,1'b0,16'h0040,8'h00,1'b1,8'h12,4'd6},  // R6
        '{1'b0,1'b0,2'b00,1'b0,16'h0030,8'h00,1'b1,8'hFF,4'd5}   // R5 byte erased
    };

    task automatic check(input logic en_exp, input logic [7:0] d_exp, input int rq);
        n_chk++;
        if (dout_en !== en_exp || dout !== d_exp) begin
            n_fail++;
            $display("FAIL R%0d: actual en=%0b dout=%02h expected en=%0b dout=%02h",
                     rq, dout_en, dout, en_exp, d_exp);
        end
    endtask

    task automatic drive(input logic c, input logic o, input logic [1:0] v,
                         input logic s, input logic [15:0] a, input logic [7:0] d);
        ce_n = c; oe_n = o; vlevel = v; sec_sel = s; addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R0 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, 8'h00, 1);                          // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, 8'h00, 1);                          // R1 first cycle after
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].ce_n, VECS[i].oe_n, VECS[i].vl, VECS[i].sec,
                  VECS[i].addr, VECS[i].din);
            check(VECS[i].en, VECS[i].dout, int'(VECS[i].req));
        end
        // R9 lock again, then R1 reset restores erased state
        drive(1'b1, 1'b0, 2'b00, 1'b0, 16'h0000, 8'h00);
        drive(1'b0, 1'b1, 2'b01, 1'b1, 16'h0000, 8'hFE);
        drive(1'b0, 1'b0, 2'b00, 1'b0, 16'h0040, 8'h00);
        check(1'b1, 8'hFF, 9);                          // R9 masked read
        rst_n = 1'b0;
        @(negedge clk);
        check(1'b0, 8'h00, 1);                          // R1 outputs cleared
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 2'b00, 1'b1, 16'h0000, 8'h00);
        check(1'b1, 8'hFF, 1);                          // R1 security reset
        drive(1'b0, 1'b0, 2'b00, 1'b0, 16'h0040, 8'h00);
        check(1'b1, 8'hFF, 1);                          // R1 array reset
        drive(1'b0, 1'b1, 2'b01, 1'b0, 16'h0240, 8'h81);
        drive(1'b1, 1'b0, 2'b01, 1'b0, 16'h0040, 8'h00);
        check(1'b1, 8'h81, 11);                         // R11 alias on write
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule